// File: doc/BRIEF.md
# H-Bridge PWM Channel Pair

This block produces the coil drive for a two-coil motor. It has two PWM channels, channel x and channel x+1. Each channel drives a plus pin and a minus pin, and each pin has its own output enable. A shared timer counts from zero up to a programmable period and then wraps. On the wrap cycle it raises a one-cycle overflow pulse. Each channel holds two duty values. The programmed duty value is written from a simple register bus. The working duty value is the one the comparator uses.

The programmed values move into the working values only on an overflow. Software can therefore write channel x and then channel x+1 during one timer period, and both new values take effect at the same edge. A 2-bit mode per channel sets how the channel's PWM signal reaches its pins:

- Half-bridge modes drive one pin and release the other.
- Full-bridge and paired full-bridge modes drive one pin with PWM and hold the other low. The sign bit of the working duty chooses which pin carries the PWM.

Top module: `hbridge_pwm_pair`

## Requirements
- R1: While rstN is low, the timer count and all duty values are zero. Every data pin is low and timerOvf is low.
- R2: The timer advances only in cycles where tickEn is high. timerOvf is high exactly when tickEn is high and the count is at or above periodCfg. In that cycle the count returns to 0, so one full period lasts periodCfg+1 enabled cycles.
- R3: A duty write changes no pin until the next timerOvf cycle. At that clock edge every programmed duty is copied into its working duty. The working duty holds at all other times.
- R4: Writing the same channel's duty several times within one period leaves only the last value, and that value takes effect at the next overflow.
- R5: A write is accepted only when wrBe is 2'b11. With any other byte-enable value the programmed duty is left unchanged.
- R6: The duty word encodes sign in bit 15 and magnitude in bits 14:0. The PWM signal is high while count < magnitude. A magnitude of 0 gives a constant low, and a magnitude of periodCfg or larger gives a constant high.
- R7: Mode 2'b00 (half bridge, minus side): the minus pin carries PWM with its enable high. The plus pin is released, with its enable low and its value low.
- R8: Mode 2'b01 (half bridge, plus side): the plus pin carries PWM with its enable high. The minus pin is released, with its enable low and its value low.
- R9: Modes 2'b10 (full) and 2'b11 (paired full): both enables are high. With sign 0 the plus pin carries PWM and the minus pin is low. With sign 1 the minus pin carries PWM and the plus pin is low.
- R10: In both half-bridge modes the sign bit has no effect on any pin.
- R11: Writing channel x (wrAddr 0) and then channel x+1 (wrAddr 1) in one period makes both new values take effect at the same overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer advance enable (prescaler strobe) |
| periodCfg | input | 11 | Last count value of the timer period |
| modeCh0 | input | 2 | Pin steering mode of channel x |
| modeCh1 | input | 2 | Pin steering mode of channel x+1 |
| wrEn | input | 1 | Duty register write strobe |
| wrAddr | input | 1 | Channel select: 0 = x, 1 = x+1 |
| wrData | input | 16 | Duty word: bit 15 sign, bits 14:0 magnitude |
| wrBe | input | 2 | Byte enables; both must be set for a write |
| timerOvf | output | 1 | One-cycle timer overflow pulse |
| pinPlus | output | 2 | Plus pin level per channel |
| pinMinus | output | 2 | Minus pin level per channel |
| pinPlusOe | output | 2 | Plus pin output enable per channel |
| pinMinusOe | output | 2 | Minus pin output enable per channel |

## Verification
The assertions check the following on every cycle:

- the overflow gating and the wrap to zero;
- the working duty holding between overflows and loading the programmed value at each overflow;
- partial writes leaving the programmed duty alone;
- a zero magnitude keeping both pins low;
- the enable and exclusivity pattern of each mode.

Some behaviour shows only across a whole timer period, so the bench scenarios measure it. These cover the exact high-time of each pin, the last-write-wins and paired-update sequences, the saturation at or above the period, and the sign being ignored in half-bridge modes.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  localparam int NCH = 2;

  typedef enum logic [1:0] {
    MODE_HALF_MINUS = 2'b00,
    MODE_HALF_PLUS  = 2'b01,
    MODE_FULL       = 2'b10,
    MODE_PAIRED     = 2'b11
  } hbMode_t;

  typedef struct packed {
    logic           copyAll;
    logic [NCH-1:0] loadProg;
  } hbStrobe_t;

endpackage

// File: rtl/hbp_ctrl.sv
module hbp_ctrl
  import hbp_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int BE_W   = 2,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [CNT_W-1:0]  periodCfg,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BE_W-1:0]   wrBe,
  output hbStrobe_t         strobe,
  output logic [CNT_W-1:0]  timerCnt
);

  logic wrFull;
  logic atEnd;

  assign wrFull = wrEn && (&wrBe);
  assign atEnd  = (timerCnt >= periodCfg);

  always_comb begin
    strobe.copyAll = tickEn && atEnd;
    for (int ch = 0; ch < NCH; ch++) begin
      strobe.loadProg[ch] = wrFull && (wrAddr == ADDR_W'(ch));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (tickEn) begin
      if (atEnd) timerCnt <= '0;
      else       timerCnt <= timerCnt + 1'b1;
    end
  end

endmodule

// File: rtl/hbp_datapath.sv
module hbp_datapath
  import hbp_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int MAG_W = 15
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  hbStrobe_t                  strobe,
  input  logic [MAG_W-1:0]           wrMag,
  input  logic                       wrSign,
  input  logic [CNT_W-1:0]           timerCnt,
  input  logic [CNT_W-1:0]           periodCfg,
  input  hbMode_t [NCH-1:0]          modeAll,
  output logic [NCH-1:0]             pinPlus,
  output logic [NCH-1:0]             pinMinus,
  output logic [NCH-1:0]             pinPlusOe,
  output logic [NCH-1:0]             pinMinusOe
);

  logic [NCH-1:0][MAG_W-1:0] progMag;
  logic [NCH-1:0][MAG_W-1:0] workMag;
  logic [NCH-1:0]            progSign;
  logic [NCH-1:0]            workSign;

  logic [MAG_W-1:0] cntExt;
  logic [MAG_W-1:0] perExt;

  assign cntExt = MAG_W'(timerCnt);
  assign perExt = MAG_W'(periodCfg);

  // programmed and working duty storage; copy uses pre-write value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progMag  <= '0;
      workMag  <= '0;
      progSign <= '0;
      workSign <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (strobe.copyAll) begin
          workMag[ch]  <= progMag[ch];
          workSign[ch] <= progSign[ch];
        end
        if (strobe.loadProg[ch]) begin
          progMag[ch]  <= wrMag;
          progSign[ch] <= wrSign;
        end
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic pwmOn;

    assign pwmOn = (workMag[ch] != '0) &&
                   ((workMag[ch] >= perExt) || (cntExt < workMag[ch]));

    always_comb begin
      unique case (modeAll[ch])
        MODE_HALF_MINUS: begin
          pinPlusOe[ch]  = 1'b0;
          pinMinusOe[ch] = 1'b1;
          pinPlus[ch]    = 1'b0;
          pinMinus[ch]   = pwmOn;
        end
        MODE_HALF_PLUS: begin
          pinPlusOe[ch]  = 1'b1;
          pinMinusOe[ch] = 1'b0;
          pinPlus[ch]    = pwmOn;
          pinMinus[ch]   = 1'b0;
        end
        default: begin
          pinPlusOe[ch]  = 1'b1;
          pinMinusOe[ch] = 1'b1;
          pinPlus[ch]    = pwmOn && !workSign[ch];
          pinMinus[ch]   = pwmOn && workSign[ch];
        end
      endcase
    end
  end

endmodule

// File: rtl/hbridge_pwm_pair.sv
module hbridge_pwm_pair
  import hbp_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [CNT_W-1:0]  periodCfg,
  input  logic [1:0]        modeCh0,
  input  logic [1:0]        modeCh1,
  input  logic              wrEn,
  input  logic [0:0]        wrAddr,
  input  logic [DUTY_W-1:0] wrData,
  input  logic [1:0]        wrBe,
  output logic              timerOvf,
  output logic [1:0]        pinPlus,
  output logic [1:0]        pinMinus,
  output logic [1:0]        pinPlusOe,
  output logic [1:0]        pinMinusOe
);

  localparam int MAG_W = DUTY_W - 1;
  localparam int BE_W  = DUTY_W / 8;

  hbStrobe_t          strobe;
  logic [CNT_W-1:0]   timerCnt;
  hbMode_t [NCH-1:0]  modeAll;

  assign modeAll[0] = hbMode_t'(modeCh0);
  assign modeAll[1] = hbMode_t'(modeCh1);
  assign timerOvf   = strobe.copyAll;

  hbp_ctrl #(
    .CNT_W (CNT_W),
    .BE_W  (BE_W),
    .ADDR_W(1)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .periodCfg(periodCfg),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrBe     (wrBe),
    .strobe   (strobe),
    .timerCnt (timerCnt)
  );

  hbp_datapath #(
    .CNT_W(CNT_W),
    .MAG_W(MAG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrMag     (wrData[MAG_W-1:0]),
    .wrSign    (wrData[DUTY_W-1]),
    .timerCnt  (timerCnt),
    .periodCfg (periodCfg),
    .modeAll   (modeAll),
    .pinPlus   (pinPlus),
    .pinMinus  (pinMinus),
    .pinPlusOe (pinPlusOe),
    .pinMinusOe(pinMinusOe)
  );

endmodule

// File: rtl/hbp_checker.sv
module hbp_checker
  import hbp_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int MAG_W = 15
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      tickEn,
  input logic                      timerOvf,
  input logic [CNT_W-1:0]          timerCnt,
  input logic                      wrEn,
  input logic [1:0]                wrBe,
  input hbMode_t [NCH-1:0]         modeAll,
  input logic [NCH-1:0][MAG_W-1:0] workMag,
  input logic [NCH-1:0][MAG_W-1:0] progMag,
  input logic [NCH-1:0]            pinPlus,
  input logic [NCH-1:0]            pinMinus,
  input logic [NCH-1:0]            pinPlusOe,
  input logic [NCH-1:0]            pinMinusOe
);

  p_ovf_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |-> !timerOvf);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timerCnt));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |=> (timerCnt == '0));

  p_work_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !timerOvf |=> $stable(workMag));

  p_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |=> (workMag == $past(progMag)));

  p_partial_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || (wrBe != 2'b11)) |=> $stable(progMag));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    p_zero_low_r6: assert property (@(posedge clk) disable iff (!rstN)
      (workMag[ch] == '0) |-> (!pinPlus[ch] && !pinMinus[ch]));

    p_half_minus_r7: assert property (@(posedge clk) disable iff (!rstN)
      (modeAll[ch] == MODE_HALF_MINUS) |-> (!pinPlusOe[ch] && pinMinusOe[ch] && !pinPlus[ch]));

    p_half_plus_r8: assert property (@(posedge clk) disable iff (!rstN)
      (modeAll[ch] == MODE_HALF_PLUS) |-> (pinPlusOe[ch] && !pinMinusOe[ch] && !pinMinus[ch]));

    p_full_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
      modeAll[ch][1] |-> (pinPlusOe[ch] && pinMinusOe[ch] && !(pinPlus[ch] && pinMinus[ch])));
  end

endmodule

bind hbridge_pwm_pair hbp_checker #(
  .CNT_W(CNT_W),
  .MAG_W(MAG_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .timerOvf  (timerOvf),
  .timerCnt  (timerCnt),
  .wrEn      (wrEn),
  .wrBe      (wrBe),
  .modeAll   (modeAll),
  .workMag   (u_dp.workMag),
  .progMag   (u_dp.progMag),
  .pinPlus   (pinPlus),
  .pinMinus  (pinMinus),
  .pinPlusOe (pinPlusOe),
  .pinMinusOe(pinMinusOe)
);

// File: tb/hbridge_pwm_pair_test.sv
module hbridge_pwm_pair_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic [10:0] periodCfg;
  logic [1:0]  modeCh0, modeCh1;
  logic        wrEn;
  logic [0:0]  wrAddr;
  logic [15:0] wrData;
  logic [1:0]  wrBe;
  logic        timerOvf;
  logic [1:0]  pinPlus, pinMinus, pinPlusOe, pinMinusOe;

  int P = 19;
  assign periodCfg = P[10:0];

  always #5 clk = ~clk;

  hbridge_pwm_pair uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .periodCfg(periodCfg),
    .modeCh0(modeCh0), .modeCh1(modeCh1), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrBe(wrBe), .timerOvf(timerOvf), .pinPlus(pinPlus),
    .pinMinus(pinMinus), .pinPlusOe(pinPlusOe), .pinMinusOe(pinMinusOe)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit compareOn = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference model
  int mCnt;
  int mMag[2], mpMag[2];
  bit mSign[2], mpSign[2];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0;
      for (int c = 0; c < 2; c++) begin
        mMag[c] = 0; mpMag[c] = 0; mSign[c] = 0; mpSign[c] = 0;
      end
    end else begin
      bit ov;
      ov = tickEn && (mCnt >= P);
      if (ov) begin
        for (int c = 0; c < 2; c++) begin
          mMag[c] = mpMag[c]; mSign[c] = mpSign[c];
        end
      end
      if (wrEn && wrBe == 2'b11) begin
        mpMag[wrAddr]  = int'(wrData[14:0]);
        mpSign[wrAddr] = wrData[15];
      end
      if (ov) mCnt = 0;
      else if (tickEn) mCnt++;
    end
  end

  function automatic int clip(input int mag);
    if (mag == 0) return 0;
    if (mag >= P) return P + 1;
    return mag;
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (compareOn) begin
      bit expOv;
      expOv = rstN && tickEn && (mCnt >= P);
      check(timerOvf == expOv, "R2", "timerOvf", int'(timerOvf), int'(expOv));
      for (int c = 0; c < 2; c++) begin
        int m;
        bit on;
        logic [3:0] expV, actV;
        string tag;
        m  = (c == 0) ? int'(modeCh0) : int'(modeCh1);
        on = (mMag[c] != 0) && ((mMag[c] >= P) || (mCnt < mMag[c]));
        case (m)
          0: expV = {1'b0, 1'b1, 1'b0, on};
          1: expV = {1'b1, 1'b0, on, 1'b0};
          default: expV = {1'b1, 1'b1, on && !mSign[c], on && mSign[c]};
        endcase
        actV = {pinPlusOe[c], pinMinusOe[c], pinPlus[c], pinMinus[c]};
        tag = (m == 0) ? "R7" : (m == 1) ? "R8" : "R9";
        check(actV == expV, tag, $sformatf("pins ch%0d {poe,moe,p,m}", c),
              int'(actV), int'(expV));
      end
    end
    if (cycles == 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 0);
      finishRun();
    end
  end

  task automatic busWrite(input int addr, input int mag, input bit sign,
                          input logic [1:0] be);
    @(negedge clk); #1;
    wrEn = 1'b1; wrAddr = addr[0:0]; wrData = {sign, mag[14:0]}; wrBe = be;
    @(negedge clk); #1;
    wrEn = 1'b0; wrBe = 2'b00;
  endtask

  task automatic waitOvf();
    forever begin
      @(negedge clk);
      if (timerOvf) break;
    end
    @(posedge clk);
  endtask

  int hp[2], hm[2];

  task automatic measureAll();
    for (int c = 0; c < 2; c++) begin hp[c] = 0; hm[c] = 0; end
    for (int i = 0; i <= P; i++) begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        hp[c] += int'(pinPlus[c]);
        hm[c] += int'(pinMinus[c]);
      end
    end
  endtask

  initial begin
    rstN = 1'b0; tickEn = 1'b1; modeCh0 = 2'b10; modeCh1 = 2'b10;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; wrBe = 2'b00;
    @(negedge clk);
    compareOn = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(pinPlus == 2'b00 && pinMinus == 2'b00, "R1", "pins in reset",
          int'({pinPlus, pinMinus}), 0);
    check(timerOvf == 1'b0, "R1", "timerOvf in reset", int'(timerOvf), 0);
    rstN = 1'b1;

    // R3: write is invisible until overflow
    begin
      int seen;
      seen = 0;
      waitOvf();
      busWrite(0, 5, 1'b0, 2'b11);
      forever begin
        @(negedge clk);
        seen += int'(pinPlus[0]);
        if (timerOvf) break;
      end
      @(posedge clk);
      check(seen == 0, "R3", "plus high cycles before overflow", seen, 0);
      measureAll();
      check(hp[0] == 5, "R3", "ch0 high cycles after overflow", hp[0], 5);
    end

    // R4: last write wins
    waitOvf();
    busWrite(0, 3, 1'b0, 2'b11);
    busWrite(0, 8, 1'b0, 2'b11);
    waitOvf();
    measureAll();
    check(hp[0] == 8, "R4", "ch0 after two writes", hp[0], 8);

    // R5: partial byte enables ignored
    waitOvf();
    busWrite(0, 12, 1'b0, 2'b01);
    busWrite(0, 13, 1'b0, 2'b10);
    waitOvf();
    measureAll();
    check(hp[0] == 8, "R5", "ch0 after partial writes", hp[0], 8);

    // R11 + R9: paired update, sign on channel x+1
    waitOvf();
    busWrite(0, 4, 1'b0, 2'b11);
    busWrite(1, 9, 1'b1, 2'b11);
    waitOvf();
    measureAll();
    check(hp[0] == 4, "R11", "ch0 new value same overflow", hp[0], 4);
    check(hm[1] == 9, "R11", "ch1 new value same overflow", hm[1], 9);
    check(hp[1] == 0, "R9", "ch1 plus low with sign 1", hp[1], 0);
    check(hm[0] == 0, "R9", "ch0 minus low with sign 0", hm[0], 0);

    // R6: boundaries
    waitOvf();
    busWrite(0, 0, 1'b0, 2'b11);
    busWrite(1, P, 1'b0, 2'b11);
    waitOvf();
    measureAll();
    check(hp[0] == 0, "R6", "magnitude 0", hp[0], 0);
    check(hp[1] == P + 1, "R6", "magnitude equal period", hp[1], P + 1);
    waitOvf();
    busWrite(0, 32767, 1'b0, 2'b11);
    busWrite(1, 1, 1'b0, 2'b11);
    waitOvf();
    measureAll();
    check(hp[0] == P + 1, "R6", "magnitude max", hp[0], P + 1);
    check(hp[1] == 1, "R6", "magnitude 1", hp[1], 1);

    // R7, R8, R10: half-bridge modes with sign set
    @(negedge clk); #1;
    modeCh0 = 2'b00; modeCh1 = 2'b01;
    waitOvf();
    busWrite(0, 6, 1'b1, 2'b11);
    busWrite(1, 7, 1'b1, 2'b11);
    waitOvf();
    measureAll();
    check(hm[0] == 6 && hp[0] == 0, "R7", "ch0 minus-side drive", hm[0], 6);
    check(pinPlusOe[0] == 1'b0, "R7", "ch0 plus released", int'(pinPlusOe[0]), 0);
    check(hp[1] == 7 && hm[1] == 0, "R10", "ch1 sign ignored", hp[1], 7);
    check(pinMinusOe[1] == 1'b0, "R8", "ch1 minus released", int'(pinMinusOe[1]), 0);
    waitOvf();
    busWrite(0, 6, 1'b0, 2'b11);
    waitOvf();
    measureAll();
    check(hm[0] == 6, "R10", "ch0 sign 0 same drive", hm[0], 6);

    // R2: tickEn low freezes the timer
    begin
      int ovs;
      logic [3:0] snap;
      ovs = 0;
      @(negedge clk); #1;
      tickEn = 1'b0;
      @(negedge clk);
      snap = {pinPlus, pinMinus};
      repeat (30) begin
        @(negedge clk);
        ovs += int'(timerOvf);
        if ({pinPlus, pinMinus} != snap) ovs += 100;
      end
      check(ovs == 0, "R2", "no overflow or pin change while disabled", ovs, 0);
      #1 tickEn = 1'b1;
    end

    // R2: period length and reprogrammed period
    begin
      int len;
      waitOvf();
      len = 1;
      forever begin
        @(negedge clk);
        if (timerOvf) break;
        len++;
      end
      check(len == P + 1, "R2", "cycles per period", len, P + 1);
      #1 P = 9;
      @(posedge clk);
      @(negedge clk); #1;
      modeCh0 = 2'b10; modeCh1 = 2'b10;
      waitOvf();
      busWrite(0, 7, 1'b0, 2'b11);
      busWrite(1, 12, 1'b0, 2'b11);
      waitOvf();
      measureAll();
      check(hp[0] == clip(7), "R6", "mag 7 short period", hp[0], clip(7));
      check(hp[1] == clip(12), "R6", "mag above short period", hp[1], clip(12));
    end

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule